// File: doc/BRIEF.md
# Reduced-Width Floating-Point Multiplier

This block multiplies two numbers held in a narrow floating-point format whose exponent and fraction widths are parameters. A word is laid out with the sign in the most significant bit, the biased exponent below it, and the fraction in the low bits. A normal value carries an implied leading one in front of its fraction. The block suits signal-processing datapaths where full single precision costs too much area and power, but the wide range of a floating-point format still helps.

Each accepted operand pair produces one registered result a single clock later. The result comes with four flags: overflow, underflow, invalid and zero. Rounding is by truncation. Operands whose exponent field is zero, including denormals, count as zero. Special values follow a small fixed rule set, so the logic stays shallow.

Top module: `lwfp_mul`

## Requirements
- R1: A word is {sign, exponent, fraction}, with the sign in bit EXP_W+FRAC_W and the fraction in bits FRAC_W-1:0. An exponent field of zero marks a zero operand, whatever the fraction holds, so denormal inputs act as zero.
- R2: Apart from the NaN case, the result sign is the XOR of the operand signs. This includes zero and infinity results.
- R3: For two normal operands, the product of the significands {1,fa}·{1,fb} is normalised in one step. When it is at least 2.0, it is shifted right by one and the exponent ea+eb−bias (bias = 2^(EXP_W−1)−1) is incremented. The fraction is the truncated top FRAC_W bits below the leading one.
- R4: If either operand is NaN (exponent all ones, fraction nonzero), or one operand is zero and the other infinite, the result is the canonical NaN. The canonical NaN has sign 0, exponent all ones, and only the fraction MSB set. The invalid flag is raised.
- R5: Infinity (exponent all ones, fraction zero) times infinity or times a nonzero finite value gives a signed infinity with all flags clear.
- R6: A zero operand times zero or a finite value gives a signed zero with the zero flag set and overflow and underflow clear.
- R7: If the normalised exponent exceeds 2^EXP_W−2, the result is a signed infinity with the overflow flag set.
- R8: If the normalised exponent is below 1, the result is a signed zero with the underflow and zero flags set.
- R9: The result and its flags appear one cycle after an input with in_valid high, and out_valid copies in_valid with that one-cycle delay. While in_valid is low, the product and flags hold.
- R10: During reset, out_valid, the product and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair is present |
| op_a | input | 1+EXP_W+FRAC_W | First operand |
| op_b | input | 1+EXP_W+FRAC_W | Second operand |
| out_valid | output | 1 | Result is present |
| product | output | 1+EXP_W+FRAC_W | Product word |
| flag_ovf | output | 1 | Result saturated to infinity |
| flag_unf | output | 1 | Result flushed to zero |
| flag_inv | output | 1 | Result is NaN |
| flag_zero | output | 1 | Result is zero |

## Verification
The block holds no state beyond its single output register, so a wrong classification, a wrong normalisation choice or a wrong exponent limit shows up at the ports on the very next cycle. It appears as a wrong product word or flag for that operand pair. The bench therefore sweeps every exponent pair, in both signs, with edge fractions. This covers every boundary between normal, overflow, underflow and special results, and it exercises both normalisation paths. A register that fails to hold while in_valid is low shows up as a product change within one idle cycle.

// File: rtl/lwfp_mul.sv
module lwfp_mul #(
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [EXP_W+FRAC_W:0]     op_a,
  input  logic [EXP_W+FRAC_W:0]     op_b,
  output logic                      out_valid,
  output logic [EXP_W+FRAC_W:0]     product,
  output logic                      flag_ovf,
  output logic                      flag_unf,
  output logic                      flag_inv,
  output logic                      flag_zero
);

  localparam int W    = 1 + EXP_W + FRAC_W;
  localparam int PW   = 2 * (FRAC_W + 1);
  localparam int EW2  = EXP_W + 2;
  localparam int BIAS = 2 ** (EXP_W - 1) - 1;
  localparam int EMAX = 2 ** EXP_W - 2;
  localparam logic [EW2-1:0] OVF_LIM = EW2'(BIAS + EMAX);
  localparam logic [EW2-1:0] UNF_LIM = EW2'(BIAS + 1);
  localparam logic [EXP_W-1:0] EXP_ONES = '1;
  localparam logic [W-1:0] NAN_WORD = {1'b0, EXP_ONES, 1'b1, {(FRAC_W-1){1'b0}}};

  logic             sa, sb, sr;
  logic [EXP_W-1:0] ea, eb;
  logic [FRAC_W-1:0] fa, fb;
  assign {sa, ea, fa} = op_a;
  assign {sb, eb, fb} = op_b;
  assign sr = sa ^ sb;

  logic a_zero, b_zero, a_inf, b_inf, a_nan, b_nan;
  assign a_zero = (ea == '0);
  assign b_zero = (eb == '0);
  assign a_inf  = (ea == EXP_ONES) && (fa == '0);
  assign b_inf  = (eb == EXP_ONES) && (fb == '0);
  assign a_nan  = (ea == EXP_ONES) && (fa != '0);
  assign b_nan  = (eb == EXP_ONES) && (fb != '0);

  logic [PW-1:0]     prod;
  logic              norm;
  logic [FRAC_W-1:0] frac_n;
  logic [EW2-1:0]    e_raw;
  logic [EXP_W-1:0]  e_out;

  assign prod   = PW'({1'b1, fa}) * PW'({1'b1, fb});
  assign norm   = prod[PW-1];
  assign frac_n = FRAC_W'(norm ? (prod >> (FRAC_W + 1)) : (prod >> FRAC_W));
  assign e_raw  = EW2'(ea) + EW2'(eb) + EW2'(norm);
  assign e_out  = EXP_W'(e_raw - EW2'(BIAS));

  logic [W-1:0] nx_word;
  logic         nx_ovf, nx_unf, nx_inv, nx_zero;

  always_comb begin
    nx_word = {sr, e_out, frac_n};
    nx_ovf  = 1'b0;
    nx_unf  = 1'b0;
    nx_inv  = 1'b0;
    nx_zero = 1'b0;
    if (a_nan || b_nan || (a_zero && b_inf) || (a_inf && b_zero)) begin
      nx_word = NAN_WORD;
      nx_inv  = 1'b1;
    end else if (a_inf || b_inf) begin
      nx_word = {sr, EXP_ONES, {FRAC_W{1'b0}}};
    end else if (a_zero || b_zero) begin
      nx_word = {sr, {(W-1){1'b0}}};
      nx_zero = 1'b1;
    end else if (e_raw > OVF_LIM) begin
      nx_word = {sr, EXP_ONES, {FRAC_W{1'b0}}};
      nx_ovf  = 1'b1;
    end else if (e_raw < UNF_LIM) begin
      nx_word = {sr, {(W-1){1'b0}}};
      nx_unf  = 1'b1;
      nx_zero = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      product   <= '0;
      flag_ovf  <= 1'b0;
      flag_unf  <= 1'b0;
      flag_inv  <= 1'b0;
      flag_zero <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        product   <= nx_word;
        flag_ovf  <= nx_ovf;
        flag_unf  <= nx_unf;
        flag_inv  <= nx_inv;
        flag_zero <= nx_zero;
      end
    end
  end

  p_valid_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == $past(in_valid));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(product) && $stable(flag_zero));

  p_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !(a_nan || b_nan || (a_zero && b_inf) || (a_inf && b_zero))
    |=> product[W-1] == $past(op_a[W-1] ^ op_b[W-1]));

  p_nan_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_inv |-> product == NAN_WORD);

  p_ovf_inf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ovf |-> product[W-2:0] == {EXP_ONES, {FRAC_W{1'b0}}});

  p_unf_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_unf |-> flag_zero && product[W-2:0] == '0);

  p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flag_ovf, flag_inv, flag_zero}));

endmodule

// File: tb/lwfp_mul_tb.sv
module lwfp_mul_tb_top;
  localparam int E = 5;
  localparam int F = 8;
  localparam int W = 1 + E + F;
  localparam int BIAS = (1 << (E - 1)) - 1;
  localparam int EALL = (1 << E) - 1;
  localparam int FMASK = (1 << F) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic out_valid, flag_ovf, flag_unf, flag_inv, flag_zero;
  logic [W-1:0] product;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  lwfp_mul #(.EXP_W(E), .FRAC_W(F)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .product(product), .flag_ovf(flag_ovf),
    .flag_unf(flag_unf), .flag_inv(flag_inv), .flag_zero(flag_zero));

  function automatic string rname(int t);
    case (t)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6"; 7: return "R7"; 8: return "R8";
      9: return "R9"; default: return "R10";
    endcase
  endfunction

  // expected flags packed as {ovf, unf, inv, zero}
  function automatic void model(input int a, input int b, output int word,
                                output int fl, output int tag);
    int sa, sb, ea, eb, fa, fb, s, n, e, fr;
    longint p;
    sa = (a >> (W-1)) & 1; sb = (b >> (W-1)) & 1;
    ea = (a >> F) & EALL;  eb = (b >> F) & EALL;
    fa = a & FMASK;        fb = b & FMASK;
    s = sa ^ sb;
    if ((ea == EALL && fa != 0) || (eb == EALL && fb != 0) ||
        (ea == 0 && eb == EALL) || (ea == EALL && eb == 0)) begin
      word = (EALL << F) | (1 << (F-1)); fl = 4'b0010; tag = 4;
    end else if (ea == EALL || eb == EALL) begin
      word = (s << (W-1)) | (EALL << F); fl = 0; tag = 5;
    end else if (ea == 0 || eb == 0) begin
      word = s << (W-1); fl = 4'b0001;
      tag = ((ea == 0 && fa != 0) || (eb == 0 && fb != 0)) ? 1 : 6;
    end else begin
      p = longint'((1 << F) + fa) * longint'((1 << F) + fb);
      n = (p >= (longint'(1) << (2*F+1))) ? 1 : 0;
      e = ea + eb - BIAS + n;
      fr = int'((p >> (F + n)) & FMASK);
      if (e > EALL - 1) begin
        word = (s << (W-1)) | (EALL << F); fl = 4'b1000; tag = 7;
      end else if (e < 1) begin
        word = s << (W-1); fl = 4'b0101; tag = 8;
      end else begin
        word = (s << (W-1)) | (e << F) | fr; fl = 0; tag = (s != 0) ? 2 : 3;
      end
    end
  endfunction

  task automatic check(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int fsel[4];
    int pa, pb, ew, efl, etag;
    fsel[0] = 0; fsel[1] = 1; fsel[2] = 1 << (F-1); fsel[3] = FMASK;
    repeat (3) @(negedge clk);
    // R10: reset values
    check("R10", {27'd0, out_valid, product, flag_ovf, flag_unf, flag_inv, flag_zero}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", int'(out_valid), 0);
    pa = 0; pb = 0; ew = 0; efl = 0; etag = 0;
    for (int ea = 0; ea <= EALL; ea++)
      for (int eb = 0; eb <= EALL; eb++)
        for (int i = 0; i < 4; i++)
          for (int j = 0; j < 4; j++) begin
            int a, b;
            a = (((ea ^ i) & 1) << (W-1)) | (ea << F) | fsel[i];
            b = (((eb + j) & 1) << (W-1)) | (eb << F) | fsel[j];
            op_a = W'(a); op_b = W'(b); in_valid = 1'b1;
            @(negedge clk);
            model(a, b, ew, efl, etag);
            check("R9", int'(out_valid), 1);
            check(rname(etag), {18'd0, product}, ew);
            check(rname(etag), {28'd0, flag_ovf, flag_unf, flag_inv, flag_zero}, efl);
            pa = a; pb = b;
          end
    // R9: idle cycles hold the last result, out_valid low
    in_valid = 1'b0;
    op_a = W'((BIAS + 1) << F); op_b = W'((BIAS + 1) << F);
    model(pa, pb, ew, efl, etag);
    repeat (3) begin
      @(negedge clk);
      check("R9", int'(out_valid), 0);
      check("R9", {18'd0, product}, ew);
      check("R9", {28'd0, flag_ovf, flag_unf, flag_inv, flag_zero}, efl);
    end
    // R3: 1.5 * 1.5 = 2.25 takes the shift path
    op_a = W'((BIAS << F) | (1 << (F-1))); op_b = op_a; in_valid = 1'b1;
    @(negedge clk);
    check("R3", {18'd0, product}, ((BIAS + 1) << F) | (1 << (F-3)));
    in_valid = 1'b0;
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule